// File: doc/BRIEF.md
# Counter-Based LRU Replacement Tracker

This block keeps true least-recently-used order for a single cache set of 2^K ways. Every way carries a K-bit age and an occupancy flag. Age 0 marks the most recent reference, and a larger age marks an older one. The tags and data live elsewhere. A cache controller instantiates one tracker per set, or it wraps the tracker around an external array of per-set state. On each lookup the controller reports a hit together with the way that hit, or it reports a miss.

The way to fill on a miss comes out combinationally from the current state. When the set still has a free way, that output is the lowest-numbered free way. When the set is full, it is the way whose age has reached 2^K-1. The controller reads this index before it raises the access strobe. On the clock edge that takes the strobe, the tracker claims that way and re-ages the whole set.

The default configuration is K=2, which gives four ways.

Top module: `lru_age_tracker`

## Requirements
- R1: A synchronous active-low reset clears every occupancy flag and every age to 0. After reset the fill-way output is 0 and set_full_o is 0.
- R2: A hit strobe on an occupied way sets that way's age to 0. Every occupied way with a smaller age than the hit way had gains 1, and all other ways keep their values. With K=2 and ages (way0..way3) = 1,0,2,3, a hit on way 2 leaves 2,1,0,3.
- R3: A hit strobe that names a way whose occupancy flag is clear changes neither the ages nor the flags.
- R4: A miss strobe while at least one way is free fills the lowest-numbered free way. That way's flag is set and its age becomes 0. Every previously occupied way gains 1.
- R5: A miss strobe in a full set replaces the way whose age is 2^K-1. That way's age becomes 0 and every other way gains 1.
- R6: victim_way_o depends only on the current state. It is the lowest-numbered free way when one exists, and otherwise the way with age 2^K-1. set_full_o is 1 exactly when all flags are set.
- R7: The ages of the occupied ways are always distinct and each is below the number of occupied ways, so no age exceeds 2^K-1.
- R8: With the access strobe low, the state is unchanged.
- R9: Occupancy flags are only cleared by reset. No access clears one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid_i | input | 1 | Access strobe; the state updates on the rising edge where this is high |
| acc_hit_i | input | 1 | 1 = hit on acc_way_i, 0 = miss (fill victim_way_o) |
| acc_way_i | input | K | Way index of the hit |
| victim_way_o | output | K | Way to fill on a miss, combinational from the state |
| set_full_o | output | 1 | All ways occupied |
| valid_o | output | 2^K | Occupancy flag of way i at bit i |
| ages_o | output | 2^K*K | Age of way i at bits [i*K +: K] |

## Verification
victim_way_o and set_full_o are combinational from the registered state. The bench therefore checks them at the falling edge before each strobe, with no access in flight. An access raised at a falling edge takes effect at the next rising edge. Its new ages and flags, and the fill way and full flag that follow from them, are checked at the falling edge after that, one cycle after the stimulus and before the next stimulus is driven. A cycle-accurate model in the bench, stepped at the same edge, supplies the expected values. The run resets every 48 steps so that the fill phase and the full-set eviction phase are each visited many times.

// File: rtl/lru_pkg.sv
// Package: shared types for the LRU age tracker.
// Assumes nothing beyond standard SystemVerilog.
package lru_pkg;

    // Operation applied to the set on a clock edge.
    typedef enum logic [1:0] {
        LRU_IDLE = 2'd0,   // no state change
        LRU_HIT  = 2'd1,   // re-age around an occupied way
        LRU_FILL = 2'd2    // claim the victim way, age everyone else
    } lru_op_e;

endpackage

// File: rtl/lru_access_decode.sv
// Module: lru_access_decode
// Turns the access strobe into an operation code and fetches the age of
// the hit way. Assumes acc_way_i indexes one of the 2^K ways; a hit on a
// way whose occupancy flag is clear is demoted to LRU_IDLE.
module lru_access_decode
    import lru_pkg::*;
#(
    parameter int K = 2,
    localparam int WAYS = 1 << K
) (
    input  logic              acc_valid_i,
    input  logic              acc_hit_i,
    input  logic [K-1:0]      acc_way_i,
    input  logic [WAYS-1:0]   valid_i,
    input  logic [WAYS*K-1:0] ages_i,
    output lru_op_e           op_o,
    output logic [K-1:0]      ref_age_o
);

    // Select the age of the referenced way.
    always_comb begin
        ref_age_o = ages_i[acc_way_i*K +: K];
    end

    // Classify the access.
    always_comb begin
        op_o = LRU_IDLE;
        if (acc_valid_i) begin
            if (!acc_hit_i) begin
                op_o = LRU_FILL;
            end else if (valid_i[acc_way_i]) begin
                op_o = LRU_HIT;
            end
        end
    end

endmodule

// File: rtl/lru_victim_pick.sv
// Module: lru_victim_pick
// Chooses the fill way from the current state: the lowest free way, or,
// in a full set, the way whose age equals 2^K-1. Assumes the ages of the
// occupied ways form a permutation, so exactly one way is oldest when full.
module lru_victim_pick #(
    parameter int K = 2,
    localparam int WAYS = 1 << K,
    localparam logic [K-1:0] AGE_MAX = K'(WAYS - 1)
) (
    input  logic [WAYS-1:0]   valid_i,
    input  logic [WAYS*K-1:0] ages_i,
    output logic [K-1:0]      victim_o,
    output logic              full_o
);

    logic [K-1:0] free_idx;
    logic [K-1:0] old_idx;

    // The set is full when every occupancy flag is set.
    always_comb begin
        full_o = &valid_i;
    end

    // Lowest-numbered free way: scan from the top so the lowest wins.
    always_comb begin
        free_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = K'(i);
            end
        end
    end

    // Way holding the maximum age.
    always_comb begin
        old_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (ages_i[i*K +: K] == AGE_MAX) begin
                old_idx = K'(i);
            end
        end
    end

    // Final choice between the two candidates.
    always_comb begin
        victim_o = full_o ? old_idx : free_idx;
    end

endmodule

// File: rtl/lru_way_cell.sv
// Module: lru_way_cell
// Holds the age and occupancy flag of one way and applies the hit and
// fill ageing rules. Assumes sel_i is high for exactly the one way that
// the operation targets (the hit way or the fill way).
module lru_way_cell
    import lru_pkg::*;
#(
    parameter int K = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lru_op_e      op_i,
    input  logic         sel_i,
    input  logic [K-1:0] ref_age_i,
    output logic [K-1:0] age_o,
    output logic         valid_o
);

    logic [K-1:0] age_nx;
    logic         valid_nx;

    // Next-state rules for this way.
    always_comb begin
        age_nx   = age_o;
        valid_nx = valid_o;
        unique case (op_i)
            LRU_HIT: begin
                if (sel_i) begin
                    age_nx = '0;
                end else if (valid_o && (age_o < ref_age_i)) begin
                    age_nx = age_o + K'(1);
                end
            end
            LRU_FILL: begin
                if (sel_i) begin
                    age_nx   = '0;
                    valid_nx = 1'b1;
                end else if (valid_o) begin
                    age_nx = age_o + K'(1);
                end
            end
            default: begin
            end
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            age_o   <= age_nx;
            valid_o <= valid_nx;
        end
    end

endmodule

// File: rtl/lru_age_tracker.sv
// Module: lru_age_tracker (top)
// True-LRU replacement state for one set of 2^K ways using per-way age
// counters. Assumes the caller reads victim_way_o before strobing a miss;
// the fill happens on the same edge that takes the strobe.
module lru_age_tracker
    import lru_pkg::*;
#(
    parameter int K = 2,
    localparam int WAYS = 1 << K
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic              acc_hit_i,
    input  logic [K-1:0]      acc_way_i,
    output logic [K-1:0]      victim_way_o,
    output logic              set_full_o,
    output logic [WAYS-1:0]   valid_o,
    output logic [WAYS*K-1:0] ages_o
);

    lru_op_e      op;
    logic [K-1:0] ref_age;
    logic [K-1:0] target_way;

    lru_access_decode #(.K(K)) u_decode (
        .acc_valid_i (acc_valid_i),
        .acc_hit_i   (acc_hit_i),
        .acc_way_i   (acc_way_i),
        .valid_i     (valid_o),
        .ages_i      (ages_o),
        .op_o        (op),
        .ref_age_o   (ref_age)
    );

    lru_victim_pick #(.K(K)) u_pick (
        .valid_i  (valid_o),
        .ages_i   (ages_o),
        .victim_o (victim_way_o),
        .full_o   (set_full_o)
    );

    // The targeted way is the hit way or, on a fill, the victim.
    always_comb begin
        target_way = (op == LRU_HIT) ? acc_way_i : victim_way_o;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic sel;
        // Decode whether this way is the target.
        always_comb begin
            sel = (target_way == K'(w));
        end
        lru_way_cell #(.K(K)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_i      (op),
            .sel_i     (sel),
            .ref_age_i (ref_age),
            .age_o     (ages_o[w*K +: K]),
            .valid_o   (valid_o[w])
        );
    end

endmodule

// File: rtl/lru_tracker_checks.sv
// Module: lru_tracker_checks
// Temporal checks on the tracker's ports, attached by bind below.
module lru_tracker_checks #(
    parameter int K = 2,
    localparam int WAYS = 1 << K
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid_i,
    input logic              acc_hit_i,
    input logic [K-1:0]      acc_way_i,
    input logic [K-1:0]      victim_way_o,
    input logic              set_full_o,
    input logic [WAYS-1:0]   valid_o,
    input logic [WAYS*K-1:0] ages_o
);

    logic [K-1:0] age_a [WAYS];
    logic         perm_bad;

    // Unpack ages for indexed access.
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            age_a[i] = ages_o[i*K +: K];
        end
    end

    // Flag duplicate or out-of-range ages among occupied ways.
    always_comb begin
        perm_bad = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid_o[i] && (int'(age_a[i]) >= $countones(valid_o))) begin
                perm_bad = 1'b1;
            end
            for (int j = i + 1; j < WAYS; j++) begin
                if (valid_o[i] && valid_o[j] && (age_a[i] == age_a[j])) begin
                    perm_bad = 1'b1;
                end
            end
        end
    end

    assert_victim_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !set_full_o |-> !valid_o[victim_way_o]);

    assert_victim_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_full_o |-> (int'(age_a[victim_way_o]) == WAYS - 1));

    assert_fill_claims_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !acc_hit_i) |=>
            (valid_o[$past(victim_way_o)] && (age_a[$past(victim_way_o)] == '0)));

    assert_hit_newest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_hit_i && valid_o[acc_way_i]) |=>
            (age_a[$past(acc_way_i)] == '0));

    assert_stale_hit_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_hit_i && !valid_o[acc_way_i]) |=>
            ($stable(ages_o) && $stable(valid_o)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> ($stable(ages_o) && $stable(valid_o)));

    assert_no_flag_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((valid_o & $past(valid_o)) == $past(valid_o)));

    assert_age_permutation_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !perm_bad);

    assert_full_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_full_o == (valid_o == '1));

endmodule

bind lru_age_tracker lru_tracker_checks #(.K(K)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid_i  (acc_valid_i),
    .acc_hit_i    (acc_hit_i),
    .acc_way_i    (acc_way_i),
    .victim_way_o (victim_way_o),
    .set_full_o   (set_full_o),
    .valid_o      (valid_o),
    .ages_o       (ages_o)
);

// File: tb/lru_age_tracker_bench.sv
`timescale 1ns/1ps
// Bench: near-exhaustive walk of a 4-way tracker against an arithmetic model.
module lru_age_tracker_bench;

    localparam int K    = 2;
    localparam int WAYS = 1 << K;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              acc_valid_i;
    logic              acc_hit_i;
    logic [K-1:0]      acc_way_i;
    logic [K-1:0]      victim_way_o;
    logic              set_full_o;
    logic [WAYS-1:0]   valid_o;
    logic [WAYS*K-1:0] ages_o;

    int errors = 0;
    int checks = 0;
    int m_age [WAYS];
    bit m_val [WAYS];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    lru_age_tracker #(.K(K)) u_lru_age_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid_i  (acc_valid_i),
        .acc_hit_i    (acc_hit_i),
        .acc_way_i    (acc_way_i),
        .victim_way_o (victim_way_o),
        .set_full_o   (set_full_o),
        .valid_o      (valid_o),
        .ages_o       (ages_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_ages();
        int v = 0;
        for (int i = 0; i < WAYS; i++) v |= (m_age[i] << (i * K));
        return v;
    endfunction

    function automatic int exp_valid();
        int v = 0;
        for (int i = 0; i < WAYS; i++) v |= (int'(m_val[i]) << i);
        return v;
    endfunction

    function automatic int exp_full();
        for (int i = 0; i < WAYS; i++) if (!m_val[i]) return 0;
        return 1;
    endfunction

    function automatic int exp_victim();
        for (int i = 0; i < WAYS; i++) if (!m_val[i]) return i;
        for (int i = 0; i < WAYS; i++) if (m_age[i] == WAYS - 1) return i;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < WAYS; i++) begin
            m_age[i] = 0;
            m_val[i] = 0;
        end
    endtask

    // Compare full state and derived outputs against the model.
    task automatic check_state(input string req);
        int bad = 0;
        int cnt = 0;
        int seen = 0;
        chk(req, int'(ages_o), exp_ages());
        chk(req, int'(valid_o), exp_valid());
        chk("R6 victim", int'(victim_way_o), exp_victim());
        chk("R6 full", int'(set_full_o), exp_full());
        for (int i = 0; i < WAYS; i++) cnt += int'(valid_o[i]);
        for (int i = 0; i < WAYS; i++) begin
            if (valid_o[i]) begin
                int a = int'(ages_o[i*K +: K]);
                if (a >= cnt || seen[a]) bad = 1;
                seen[a] = 1'b1;
            end
        end
        chk("R7 permutation", bad, 0);
    endtask

    // One access: drive at falling edge, update at rising edge, check next falling edge.
    task automatic step(input bit v, input bit h, input int w);
        string req;
        int vic = exp_victim();
        int ref_age = m_age[w];
        acc_valid_i = v;
        acc_hit_i   = h;
        acc_way_i   = K'(w);
        @(posedge clk);
        if (!v) begin
            req = "R8 idle";
        end else if (h && !m_val[w]) begin
            req = "R3 stale hit";
        end else if (h) begin
            req = "R2 hit";
            for (int i = 0; i < WAYS; i++)
                if (i != w && m_val[i] && m_age[i] < ref_age) m_age[i]++;
            m_age[w] = 0;
        end else begin
            req = (exp_full() != 0) ? "R5 evict" : "R4 fill";
            for (int i = 0; i < WAYS; i++)
                if (i != vic && m_val[i]) m_age[i]++;
            m_age[vic] = 0;
            m_val[vic] = 1'b1;
        end
        @(negedge clk);
        acc_valid_i = 1'b0;
        check_state(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        acc_valid_i = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 reset");
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        acc_valid_i = 1'b0;
        acc_hit_i = 1'b0;
        acc_way_i = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        do_reset();
        // Stale hits on an empty set (R3), then fills in order (R4).
        for (int w = 0; w < WAYS; w++) step(1'b1, 1'b1, w);
        for (int w = 0; w < WAYS; w++) step(1'b1, 1'b0, 0);
        // Build ages 1,0,2,3 and hit way 2 (R2 worked example).
        step(1'b1, 1'b1, 3);
        step(1'b1, 1'b1, 2);
        step(1'b1, 1'b1, 0);
        step(1'b1, 1'b1, 1);
        chk("R2 example before", int'(ages_o), (3 << 6) | (2 << 4) | (0 << 2) | 1);
        step(1'b1, 1'b1, 2);
        chk("R2 example after", int'(ages_o), (3 << 6) | (0 << 4) | (1 << 2) | 2);
        // Eviction of the oldest way in a full set (R5).
        chk("R5 victim is way3", int'(victim_way_o), 3);
        step(1'b1, 1'b0, 0);
        // Pseudo-random walk with periodic resets (R1..R9).
        for (int n = 0; n < 1500; n++) begin
            if (n % 48 == 47) begin
                do_reset();
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (lfsr[1:0])
                    2'd0:    step(1'b0, lfsr[2], int'(lfsr[4:3]));
                    2'd1:    step(1'b1, 1'b0, int'(lfsr[4:3]));
                    default: step(1'b1, 1'b1, int'(lfsr[4:3]));
                endcase
            end
        end
        // Reset in a full set clears everything (R1, R9).
        do_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule